// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block is the read side of an SDRAM controller for rows that are already open. A client hands it one request at a time. Each request names a bank, a starting column, a burst length, whether the row should close when the burst ends, and whether it may cut into the burst now in flight. The sequencer drives the command and address pins with a READ. It then walks the column through the burst and captures each returned data word at the programmed CAS latency. Every captured word is presented with a valid strobe, a first-of-burst flag and the column it came from.

Requests are scheduled at command time. A request that does not cut in is held back by the handshake until the last column of the running burst has been scheduled, and it is accepted in the very next cycle. The new READ therefore reaches the memory CAS-latency-minus-one cycles before the last word of the old burst is valid, and the data stream has no gap. A request that cuts in is accepted at once. Old-burst columns that have not yet been scheduled are dropped, so they never appear at the output. A full-page burst runs on past column 255 back to column 0 until such a request stops it.

Top module: `sdram_rd_seq`

## Requirements
- R1: Out of reset, and in every cycle that does not follow an accepted request, the command pins carry a NOP: chip select low and the RAS, CAS and WE strobes all high. After reset, rd_valid, rd_first and dq_listen are low.
- R2: In the cycle after a request is accepted (req_valid and req_ready both high at a clock edge), the pins carry a READ: chip select low, RAS high, CAS low, WE high. The bank pins carry the request bank, and address bits 7:0 carry the starting column.
- R3: In that READ, address bit 10 equals the request's auto-precharge flag. All other address bits are zero.
- R4: With cas_lat set to 1, 2 or 3, the first word is captured at the clock edge that comes cas_lat edges after the edge at which the memory samples the READ. rd_valid is high in the cycle after that capture edge, and each later word of the burst follows in the next cycle.
- R5: req_blen 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 words, and codes 4 to 6 also select 8 words. Column tags rise by one per word, modulo 256.
- R6: req_blen 7 selects a full-page burst. It wraps from column 255 to column 0 and keeps producing words with no end of its own.
- R7: A request with req_chain low is held off (req_ready low) while the running burst still has columns to schedule. It is accepted in the cycle right after the last of them, so its first word directly follows the old burst's last word.
- R8: A request with req_chain high is accepted in any cycle and cuts the running burst short. Old-burst words that would have followed the new burst's first word are never reported. rd_first is high only on the first word of each burst.
- R9: READs may be issued in consecutive cycles, to the same bank or to different banks. Each issued READ delivers its words in order.
- R10: dq_listen is high in exactly those cycles whose closing clock edge captures a data word. It is low whenever no burst data is expected on the bus.
- R11: rd_data equals the value on sdr_dq_in at the capture edge of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cas_lat | input | 2 | CAS latency in cycles (1 to 3); changed only while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Starting column |
| req_blen | input | 3 | Burst length code |
| req_ap | input | 1 | Close the row when the burst ends |
| req_chain | input | 1 | Cut in immediately, truncating the running burst |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | 2 | Bank select pins |
| sdr_addr | output | 13 | Address pins |
| sdr_dq_in | input | 32 | Data from the memory |
| dq_listen | output | 1 | Memory expected to drive data this cycle |
| rd_valid | output | 1 | Captured word valid |
| rd_first | output | 1 | Word is the first of its burst |
| rd_col | output | 8 | Column of the captured word |
| rd_data | output | 32 | Captured word |

## Verification
The bench runs every CAS latency through several scenarios. These cover bursts of each length and the wrap of a fixed burst past column 255, back-to-back requests held waiting, chained requests issued every cycle to different banks, a truncation partway through an 8-word burst, and a full page that wraps and is then cut. A design that releases a waiting request one cycle late leaves a hole in the data stream, and one that releases it early drops the old burst's last word. Either error shows up in the acceptance timing and in the per-cycle output map. A design that keeps scheduling the old burst after a cut reports stale columns after the new first word. A capture tap off by one moves every word by a cycle. A column counter that stops at 255 corrupts the wrapped words.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP  = 4'b0111;
  localparam sdr_cmd_t CMD_READ = 4'b0101;

  localparam logic [2:0] BLEN_PAGE = 3'b111;

  function automatic logic blen_is_page(input logic [2:0] code);
    return code == BLEN_PAGE;
  endfunction

  // words in a fixed burst; codes 3..6 all mean eight
  function automatic logic [3:0] blen_words(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/rd_burst_sched.sv
module rd_burst_sched
  import sdram_rd_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [COL_W-1:0] issue_col,
  input  logic [2:0]       issue_blen,
  output logic             push_v,
  output logic             push_first,
  output logic [COL_W-1:0] push_col,
  output logic             busy
);

  logic [COL_W-1:0] cur_col;
  logic [CNT_W-1:0] rem;
  logic             page;

  // columns still to schedule after the current cycle
  assign busy       = page | (rem != '0);
  assign push_v     = issue | busy;
  assign push_first = issue;
  assign push_col   = issue ? issue_col : cur_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_col <= '0;
      rem     <= '0;
      page    <= 1'b0;
    end else if (issue) begin
      cur_col <= issue_col + COL_W'(1);
      rem     <= CNT_W'(blen_words(issue_blen) - 4'd1);
      page    <= blen_is_page(issue_blen);
    end else if (busy) begin
      cur_col <= cur_col + COL_W'(1);
      if (!page) rem <= rem - CNT_W'(1);
    end
  end

  p_fixed_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!page && rem == CNT_W'(1) && !issue) |=> !busy);

  p_page_persists_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (page && !issue) |=> busy);

endmodule

// File: rtl/rd_cmd_issuer.sv
module rd_cmd_issuer
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_chain,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  input  logic              busy,
  output logic              req_ready,
  output logic              issue,
  output sdr_cmd_t          cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  function automatic logic [ADDR_W-1:0] read_addr(input logic [COL_W-1:0] col,
                                                  input logic ap);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[COL_W-1:0] = col;
    a[AP_BIT] = ap;
    return a;
  endfunction

  // a cutting request goes at once; otherwise wait for the burst's last column
  assign req_ready = req_chain | ~busy;
  assign issue     = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      cmd <= issue ? CMD_READ : CMD_NOP;
      if (issue) begin
        ba   <= req_bank;
        addr <= read_addr(req_col, req_ap);
      end
    end
  end

  p_nop_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue) |-> cmd == CMD_NOP);

  p_read_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue) |-> (cmd == CMD_READ && ba == $past(req_bank)
                      && addr[COL_W-1:0] == $past(req_col)));

endmodule

// File: rtl/rd_capture_pipe.sv
module rd_capture_pipe #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic              push_v,
  input  logic              push_first,
  input  logic [COL_W-1:0]  push_col,
  input  logic [DATA_W-1:0] dq,
  output logic              dq_listen,
  output logic              rd_valid,
  output logic              rd_first,
  output logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data
);

  logic [MAX_CL:0]  pv;
  logic [MAX_CL:0]  pf;
  logic [COL_W-1:0] pc [MAX_CL+1];
  logic [CL_W-1:0]  tap;

  function automatic logic [CL_W-1:0] clamp_cl(input logic [CL_W-1:0] c);
    if (c == '0) return CL_W'(1);
    if (int'(c) > MAX_CL) return CL_W'(MAX_CL);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv[0] <= 1'b0;
      pf[0] <= 1'b0;
      pc[0] <= '0;
    end else begin
      pv[0] <= push_v;
      pf[0] <= push_first;
      pc[0] <= push_col;
    end
  end

  for (genvar i = 1; i <= MAX_CL; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv[i] <= 1'b0;
        pf[i] <= 1'b0;
        pc[i] <= '0;
      end else begin
        pv[i] <= pv[i-1];
        pf[i] <= pf[i-1];
        pc[i] <= pc[i-1];
      end
    end
  end

  assign tap       = clamp_cl(cas_lat);
  assign dq_listen = pv[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_first <= 1'b0;
      rd_col   <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pv[tap];
      rd_first <= pv[tap] & pf[tap];
      if (pv[tap]) begin
        rd_col  <= pc[tap];
        rd_data <= dq;
      end
    end
  end

  p_col_consec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_first) |-> rd_col == $past(rd_col) + COL_W'(1));

  p_first_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_first) |-> $past(rd_valid));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_listen |=> !rd_valid);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(MAX_CL+1)-1:0]  cas_lat,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [BANK_W-1:0]            req_bank,
  input  logic [COL_W-1:0]             req_col,
  input  logic [2:0]                   req_blen,
  input  logic                         req_ap,
  input  logic                         req_chain,
  output logic                         sdr_cs_n,
  output logic                         sdr_ras_n,
  output logic                         sdr_cas_n,
  output logic                         sdr_we_n,
  output logic [BANK_W-1:0]            sdr_ba,
  output logic [ADDR_W-1:0]            sdr_addr,
  input  logic [DATA_W-1:0]            sdr_dq_in,
  output logic                         dq_listen,
  output logic                         rd_valid,
  output logic                         rd_first,
  output logic [COL_W-1:0]             rd_col,
  output logic [DATA_W-1:0]            rd_data
);

  localparam int CL_W  = $clog2(MAX_CL + 1);
  localparam int CNT_W = 4;

  logic             issue;
  logic             busy;
  logic             push_v;
  logic             push_first;
  logic [COL_W-1:0] push_col;
  sdr_cmd_t         cmd;

  rd_cmd_issuer #(
    .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_chain(req_chain), .req_bank(req_bank),
    .req_col(req_col), .req_ap(req_ap), .busy(busy),
    .req_ready(req_ready), .issue(issue), .cmd(cmd),
    .ba(sdr_ba), .addr(sdr_addr)
  );

  rd_burst_sched #(.COL_W(COL_W), .CNT_W(CNT_W)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .issue(issue), .issue_col(req_col), .issue_blen(req_blen),
    .push_v(push_v), .push_first(push_first), .push_col(push_col),
    .busy(busy)
  );

  rd_capture_pipe #(
    .COL_W(COL_W), .DATA_W(DATA_W), .MAX_CL(MAX_CL), .CL_W(CL_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
    .push_v(push_v), .push_first(push_first), .push_col(push_col),
    .dq(sdr_dq_in), .dq_listen(dq_listen),
    .rd_valid(rd_valid), .rd_first(rd_first), .rd_col(rd_col), .rd_data(rd_data)
  );

  assign sdr_cs_n  = cmd.cs_n;
  assign sdr_ras_n = cmd.ras_n;
  assign sdr_cas_n = cmd.cas_n;
  assign sdr_we_n  = cmd.we_n;

endmodule

// File: tb/tb_sdram_rd_seq.sv
module tb_sdram_rd_seq;
  localparam int MAPN = 8192;
  localparam int WIN  = 700;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cas_lat = 2'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_col = '0;
  logic [2:0]  req_blen = '0;
  logic        req_ap = 1'b0;
  logic        req_chain = 1'b0;
  logic        sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;
  logic [1:0]  sdr_ba;
  logic [12:0] sdr_addr;
  logic [31:0] sdr_dq_in = '0;
  logic        dq_listen, rd_valid, rd_first;
  logic [7:0]  rd_col;
  logic [31:0] rd_data;

  sdram_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_col(req_col), .req_blen(req_blen), .req_ap(req_ap), .req_chain(req_chain),
    .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n),
    .sdr_we_n(sdr_we_n), .sdr_ba(sdr_ba), .sdr_addr(sdr_addr),
    .sdr_dq_in(sdr_dq_in), .dq_listen(dq_listen), .rd_valid(rd_valid),
    .rd_first(rd_first), .rd_col(rd_col), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0, tb_cl = 1;
  bit done = 0;
  bit         exp_v [MAPN];
  bit         exp_f [MAPN];
  logic [7:0] exp_c [MAPN];
  logic [1:0] exp_b [MAPN];
  int prev_e = 0, prev_len = 0;
  bit waiting = 0, chk_cmd = 0;
  logic [7:0] e_col; logic [1:0] e_bank; logic e_ap;
  int         mn [8];
  logic [7:0] mc [8];
  logic [1:0] mb [8];
  int mk = 0;

  function automatic logic [31:0] pat(input logic [1:0] b, input logic [7:0] c);
    return {6'd0, b, 8'h3C, c, c ^ 8'h5A};
  endfunction

  function automatic int words_of(input logic [2:0] code);
    if (code == 3'd7) return WIN;
    if (code == 3'd0) return 1;
    if (code == 3'd1) return 2;
    if (code == 3'd2) return 4;
    return 8;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  initial for (int i = 0; i < 8; i++) mn[i] = -100;

  // acceptance monitor, expectation map and memory command capture
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && req_valid && req_ready) begin
      int t0, n;
      if (!req_chain && waiting && prev_len > 0)
        check(cyc == prev_e + prev_len, "R7 gapless accept edge", cyc, prev_e + prev_len);
      t0 = cyc + tb_cl + 1;
      for (int t = t0; t < t0 + WIN; t++) exp_v[t] = 1'b0;
      n = words_of(req_blen);
      for (int k = 0; k < n; k++) begin
        exp_v[t0+k] = 1'b1;
        exp_f[t0+k] = (k == 0);
        exp_c[t0+k] = 8'(int'(req_col) + k);
        exp_b[t0+k] = req_bank;
      end
      prev_e = cyc;
      prev_len = (req_blen == 3'd7) ? 0 : n;
      waiting = 1'b0;
      chk_cmd = 1'b1;
      e_col = req_col; e_bank = req_bank; e_ap = req_ap;
    end else begin
      waiting = rst_n && req_valid;
    end
    if ({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0101) begin
      mn[mk] = cyc; mc[mk] = sdr_addr[7:0]; mb[mk] = sdr_ba;
      mk = (mk + 1) % 8;
    end
  end

  // output checks and memory data drive, away from the active edge
  always @(negedge clk) begin
    int m;
    bit found;
    check(rd_valid == exp_v[cyc], "R4 word timing", rd_valid, exp_v[cyc]);
    if (exp_v[cyc] && rd_valid) begin
      check(rd_col == exp_c[cyc], "R5 column tag", rd_col, exp_c[cyc]);
      check(rd_data == pat(exp_b[cyc], exp_c[cyc]), "R11 data", rd_data,
            pat(exp_b[cyc], exp_c[cyc]));
      check(rd_first == exp_f[cyc], "R8 first flag", rd_first, exp_f[cyc]);
    end else if (!exp_v[cyc]) begin
      check(rd_first == 1'b0, "R1 first low when idle", rd_first, 0);
    end
    check(dq_listen == exp_v[cyc+1], "R10 listen window", dq_listen, exp_v[cyc+1]);
    if (chk_cmd) begin
      check({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0101, "R2 READ encoding",
            {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}, 4'b0101);
      check(sdr_ba == e_bank && sdr_addr[7:0] == e_col, "R2 bank and column",
            {sdr_ba, sdr_addr[7:0]}, {e_bank, e_col});
      check(sdr_addr[10] == e_ap && (sdr_addr & 13'h1B00) == 13'h0, "R3 auto precharge bit",
            sdr_addr, {2'b00, e_ap, 2'b00, e_col});
      chk_cmd = 1'b0;
    end else begin
      check({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0111, "R1 NOP when idle",
            {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n}, 4'b0111);
    end
    m = cyc + 1;
    found = 1'b0;
    sdr_dq_in = 32'hBAD0_0000 | 32'(cyc);
    for (int i = 1; i <= 8; i++) begin
      int idx;
      idx = (mk - i + 8) % 8;
      if (!found && mn[idx] + tb_cl <= m) begin
        found = 1'b1;
        sdr_dq_in = pat(mb[idx], 8'(int'(mc[idx]) + (m - mn[idx] - tb_cl)));
      end
    end
  end

  task automatic send(input logic [1:0] b, input logic [7:0] c, input logic [2:0] bl,
                      input logic ap, input logic ch);
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_col = c; req_blen = bl;
    req_ap = ap; req_chain = ch;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int cl = 1; cl <= 3; cl++) begin
      @(negedge clk);
      cas_lat = 2'(cl); tb_cl = cl;
      idle(6);
      // R5 each length, wrap in a fixed burst, spare code
      send(2'd0, 8'h10, 3'd0, 1'b0, 1'b0); idle(8);
      send(2'd1, 8'h20, 3'd1, 1'b1, 1'b0); idle(8);
      send(2'd2, 8'h30, 3'd2, 1'b0, 1'b0); idle(8);
      send(2'd3, 8'hFE, 3'd3, 1'b1, 1'b0); idle(12);
      send(2'd0, 8'h40, 3'd5, 1'b0, 1'b0); idle(12);
      // R7 waiting requests released without a gap
      send(2'd1, 8'h50, 3'd2, 1'b0, 1'b0);
      send(2'd2, 8'h60, 3'd0, 1'b1, 1'b0);
      send(2'd3, 8'h70, 3'd1, 1'b0, 1'b0);
      send(2'd0, 8'h80, 3'd3, 1'b0, 1'b0);
      idle(14);
      // R9 READ every cycle across banks
      send(2'd0, 8'h90, 3'd0, 1'b0, 1'b1);
      send(2'd1, 8'hA0, 3'd0, 1'b0, 1'b1);
      send(2'd1, 8'hA8, 3'd1, 1'b0, 1'b1);
      send(2'd2, 8'hB0, 3'd0, 1'b1, 1'b1);
      idle(10);
      // R8 cut an 8-word burst after three words
      send(2'd3, 8'hC0, 3'd3, 1'b0, 1'b0);
      idle(2);
      send(2'd2, 8'hD0, 3'd2, 1'b0, 1'b1);
      idle(10);
      // R6 full page wraps, then is cut
      send(2'd1, 8'hF0, 3'd7, 1'b1, 1'b0);
      idle(300);
      send(2'd0, 8'h05, 3'd1, 1'b0, 1'b1);
      idle(10);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R1-wide run hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule